// File: doc/BRIEF.md
# EEPROM Write Qualification Gate

This block sits between the asynchronous control pins of a parallel EEPROM and the logic that runs a program cycle. It decides, on a fast system clock, whether a write may begin. Two digital flags from supply monitors are inputs. One says the supply has sagged under the lockout level. The other says the supply has climbed past the power-up level. The active-low chip-enable, output-enable and write-enable pins are also inputs.

All five inputs are resynchronised first. A power-up timer then holds writes off for a programmable number of cycles after the supply becomes good. A width filter ignores short combined enable pulses. The block emits one single-cycle start pulse for each qualified enable assertion. A status output shows whether the power-up lockout still holds.

Durations are parameters counted in clock cycles: the power-up hold-off is `POWERUP_CYCLES` and the minimum enable width is `MIN_LOW_CYCLES`.

Top module: `eeprom_write_gate`

## Requirements
- R1: While reset is held and just after it is released, `wr_start_o` is 0 and `lockout_o` is 1.
- R2: Every pin and flag input passes through a two-stage synchroniser. The supply-good condition and the enable pins therefore act on the outputs only after two clock edges of latency, in addition to the delays stated below.
- R3: Suppose both supply conditions become good (`supply_low_i`=0, `supply_ok_i`=1) and stay good, with the inputs first sampled good on edge 1. Then `lockout_o` falls right after edge `POWERUP_CYCLES`+2 and not earlier.
- R4: `supply_low_i`=1 sampled on an edge raises `lockout_o` no later than three edges after it. The power-up count restarts from zero, so a fresh full delay of R3 is needed after the flag clears.
- R5: `supply_ok_i`=0 has the same effect as R4: the lockout returns and the count restarts from zero.
- R6: The output-enable pin low (`oe_n_i`=0) prevents any start pulse.
- R7: A start pulse needs both `ce_n_i`=0 and `we_n_i`=0. If either pin is high, no start pulse is produced.
- R8: A combined write pulse is `ce_n_i`=0, `we_n_i`=0 and `oe_n_i`=1 held together. If it lasts fewer than `MIN_LOW_CYCLES` sampled cycles, it produces no start pulse.
- R9: A combined write pulse of at least `MIN_LOW_CYCLES` cycles produces exactly one start pulse, one cycle wide. If the pulse is first sampled on edge 1, the start pulse appears right after edge `MIN_LOW_CYCLES`+2.
- R10: After a start pulse, no further start pulse occurs until `ce_n_i` and `we_n_i` have both been high together. This holds however long the enables stay low, and even if `oe_n_i` or one enable toggles in between.
- R11: No start pulse is produced while `lockout_o` is 1. Qualification is judged in the cycle where the pulse reaches the minimum width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_low_i | input | 1 | Supply under lockout level (1 = low) |
| supply_ok_i | input | 1 | Supply above power-up level (1 = good) |
| ce_n_i | input | 1 | Chip enable pin, active low |
| oe_n_i | input | 1 | Output enable pin, active low |
| we_n_i | input | 1 | Write enable pin, active low |
| wr_start_o | output | 1 | One-cycle write start pulse |
| lockout_o | output | 1 | Power-up lockout still active |

## Verification
The bench sweeps every pattern of the three pins against every pulse length around the minimum width. A filter off by one would either pass the shortest rejected pulse or drop the first accepted one. A wrong pin decode would start writes with output-enable low or with only one enable down. The power-up delay is measured to the exact edge, both from a clean start and after a supply-low or supply-good glitch in the middle of the count. A counter that resumes instead of restarting, or that skips the synchroniser, would release early. Long holds, an output-enable toggle under held enables, and a write-enable bounce while chip-enable stays low each expose a gate that re-arms too eagerly and fires twice.

// File: rtl/gate_pkg.sv
package gate_pkg;

   typedef struct packed {
      logic low;
      logic good;
      logic ce_n;
      logic oe_n;
      logic we_n;
   } gate_in_t;

   localparam int GATE_IN_W = $bits(gate_in_t);

   // Safe value for the synchroniser after reset: supply not good, pins idle.
   localparam gate_in_t GATE_IN_IDLE = '{low: 1'b0, good: 1'b0, ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/gate_sync.sv
module gate_sync #(
   parameter int               WIDTH     = 5,
   parameter int               STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gate_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("gate_sync: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] chain_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= RESET_VAL;
               else        chain_q[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= RESET_VAL;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gate_powerup.sv
module gate_powerup #(
   parameter int DELAY_CYCLES = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_low,
   input  logic supply_good,
   output logic lockout
);

   localparam int             CW    = $clog2(DELAY_CYCLES + 1);
   localparam logic [CW-1:0]  LIMIT = CW'(DELAY_CYCLES);

   generate
      if (DELAY_CYCLES < 1) begin : g_bad_delay
         $error("gate_powerup: DELAY_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] elapsed_q;
   logic          supply_fine;

   assign supply_fine = supply_good && !supply_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed_q <= '0;
      end else if (!supply_fine) begin
         elapsed_q <= '0;
      end else if (elapsed_q != LIMIT) begin
         elapsed_q <= elapsed_q + 1'b1;
      end
   end

   assign lockout = (elapsed_q != LIMIT);

endmodule

// File: rtl/gate_qualify.sv
module gate_qualify #(
   parameter int MIN_LOW_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   input  logic permit,
   output logic start
);

   generate
      if (MIN_LOW_CYCLES < 1) begin : g_bad_width
         $error("gate_qualify: MIN_LOW_CYCLES must be at least 1");
      end
   endgenerate

   logic active;
   logic released;
   logic fire;
   logic armed_q;
   logic start_q;

   assign active   = !ce_n && !we_n && oe_n;
   assign released = ce_n && we_n;

   generate
      if (MIN_LOW_CYCLES == 1) begin : g_edge
         logic active_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) active_q <= 1'b0;
            else        active_q <= active;
         end
         assign fire = active && !active_q && permit && armed_q;
      end else begin : g_count
         localparam int            WCW     = $clog2(MIN_LOW_CYCLES + 1);
         localparam logic [WCW-1:0] SAT    = WCW'(MIN_LOW_CYCLES);
         localparam logic [WCW-1:0] FIRE_AT = WCW'(MIN_LOW_CYCLES - 1);
         logic [WCW-1:0] width_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               width_q <= '0;
            end else if (!active) begin
               width_q <= '0;
            end else if (width_q != SAT) begin
               width_q <= width_q + 1'b1;
            end
         end
         assign fire = active && permit && armed_q && (width_q == FIRE_AT);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         start_q <= 1'b0;
      end else begin
         start_q <= fire;
         if (fire)          armed_q <= 1'b0;
         else if (released) armed_q <= 1'b1;
      end
   end

   assign start = start_q;

endmodule

// File: rtl/eeprom_write_gate.sv
module eeprom_write_gate
   import gate_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter int POWERUP_CYCLES = 10000,
   parameter int MIN_LOW_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_low_i,
   input  logic supply_ok_i,
   input  logic ce_n_i,
   input  logic oe_n_i,
   input  logic we_n_i,
   output logic wr_start_o,
   output logic lockout_o
);

   gate_in_t raw;
   gate_in_t synced;
   logic     locked;
   logic     permit;

   assign raw = '{low: supply_low_i, good: supply_ok_i,
                  ce_n: ce_n_i, oe_n: oe_n_i, we_n: we_n_i};

   gate_sync #(
      .WIDTH    (GATE_IN_W),
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(GATE_IN_IDLE)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (raw),
      .q_o  (synced)
   );

   gate_powerup #(
      .DELAY_CYCLES(POWERUP_CYCLES)
   ) u_powerup (
      .clk        (clk),
      .rst_n      (rst_n),
      .supply_low (synced.low),
      .supply_good(synced.good),
      .lockout    (locked)
   );

   assign permit = !locked && synced.good && !synced.low;

   gate_qualify #(
      .MIN_LOW_CYCLES(MIN_LOW_CYCLES)
   ) u_qualify (
      .clk   (clk),
      .rst_n (rst_n),
      .ce_n  (synced.ce_n),
      .oe_n  (synced.oe_n),
      .we_n  (synced.we_n),
      .permit(permit),
      .start (wr_start_o)
   );

   assign lockout_o = locked;

endmodule

// File: rtl/gate_checks.sv
module gate_checks (
   input logic clk,
   input logic rst_n,
   input logic supply_low_i,
   input logic supply_ok_i,
   input logic ce_n_i,
   input logic oe_n_i,
   input logic we_n_i,
   input logic wr_start_o,
   input logic lockout_o
);

   AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start_o |=> !wr_start_o); // R9

   AST_NO_START_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start_o |-> !lockout_o); // R11

   AST_LOW_FORCES_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $past(supply_low_i, 3) |-> lockout_o); // R4

   AST_NOT_GOOD_FORCES_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!supply_ok_i, 3) |-> lockout_o); // R5

   AST_START_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start_o |-> $past(!ce_n_i && !we_n_i, 3)); // R7

   AST_START_NEEDS_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start_o |-> $past(oe_n_i, 3)); // R6

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!wr_start_o && lockout_o); // R1
      end
   end

endmodule

bind eeprom_write_gate gate_checks u_gate_checks (
   .clk         (clk),
   .rst_n       (rst_n),
   .supply_low_i(supply_low_i),
   .supply_ok_i (supply_ok_i),
   .ce_n_i      (ce_n_i),
   .oe_n_i      (oe_n_i),
   .we_n_i      (we_n_i),
   .wr_start_o  (wr_start_o),
   .lockout_o   (lockout_o)
);

// File: tb/tb_eeprom_write_gate.sv
module tb_eeprom_write_gate;

   localparam int CLK_PERIOD = 10;
   localparam int P = 12;
   localparam int M = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_low_i = 1'b0;
   logic supply_ok_i = 1'b0;
   logic ce_n_i = 1'b1;
   logic oe_n_i = 1'b1;
   logic we_n_i = 1'b1;
   logic wr_start_o;
   logic lockout_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   eeprom_write_gate #(
      .SYNC_STAGES   (2),
      .POWERUP_CYCLES(P),
      .MIN_LOW_CYCLES(M)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .supply_low_i(supply_low_i),
      .supply_ok_i (supply_ok_i),
      .ce_n_i      (ce_n_i),
      .oe_n_i      (oe_n_i),
      .we_n_i      (we_n_i),
      .wr_start_o  (wr_start_o),
      .lockout_o   (lockout_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Counts negedges until lockout_o is low; each negedge follows one posedge.
   task automatic measure_unlock(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (lockout_o && n < 1000);
   endtask

   task automatic idle_pins(input int cyc);
      ce_n_i = 1'b1; we_n_i = 1'b1; oe_n_i = 1'b1;
      repeat (cyc) @(negedge clk);
   endtask

   // Called at a negedge. Pins held for L edges, then released.
   task automatic run_pulse(input int L, input bit ce_low, input bit we_low, input bit oe_v,
                            output int cnt, output int first);
      cnt = 0;
      first = 0;
      ce_n_i = !ce_low; we_n_i = !we_low; oe_n_i = oe_v;
      for (int e = 1; e <= L + M + 6; e++) begin
         @(negedge clk);
         if (wr_start_o) begin
            cnt++;
            if (first == 0) first = e;
         end
         if (e == L) begin
            ce_n_i = 1'b1; we_n_i = 1'b1; oe_n_i = 1'b1;
         end
      end
      idle_pins(3);
   endtask

   // Counts start pulses over a number of negedges, pins left as they are.
   task automatic count_starts(input int cyc, inout int cnt);
      repeat (cyc) begin
         @(negedge clk);
         if (wr_start_o) cnt++;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n;
      int cnt;
      int first;

      repeat (3) @(negedge clk);
      check(wr_start_o == 1'b0, "R1 start in reset", wr_start_o, 0);
      check(lockout_o == 1'b1, "R1 lockout in reset", lockout_o, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(lockout_o == 1'b1, "R1 lockout after reset", lockout_o, 1);
      repeat (4) @(negedge clk);
      check(lockout_o == 1'b1, "R5 lockout with supply not good", lockout_o, 1);

      // R3/R2: exact power-up delay
      supply_ok_i = 1'b1;
      measure_unlock(n);
      check(n == P + 2, "R3 R2 power-up delay edges", n, P + 2);

      // R6 R7 R8 R9: sweep pin patterns against pulse lengths
      for (int L = 1; L <= M + 4; L++) begin
         for (int pat = 0; pat < 8; pat++) begin
            bit ce_low = pat[0];
            bit we_low = pat[1];
            bit oe_v   = pat[2];
            bit valid  = ce_low && we_low && oe_v;
            bit expect_fire = valid && (L >= M);
            string tag;
            if (!oe_v)                tag = "R6 oe low";
            else if (!valid)          tag = "R7 enable high";
            else if (L < M)           tag = "R8 short pulse";
            else                      tag = "R9 long pulse";
            run_pulse(L, ce_low, we_low, oe_v, cnt, first);
            check(cnt == (expect_fire ? 1 : 0), tag, cnt, expect_fire ? 1 : 0);
            if (expect_fire)
               check(first == M + 2, "R9 R2 start edge", first, M + 2);
         end
      end

      // R10: long hold fires once
      run_pulse(30, 1'b1, 1'b1, 1'b1, cnt, first);
      check(cnt == 1, "R10 long hold single start", cnt, 1);

      // R10: oe toggled while enables held low
      cnt = 0;
      ce_n_i = 1'b0; we_n_i = 1'b0; oe_n_i = 1'b1;
      count_starts(10, cnt);
      oe_n_i = 1'b0;
      count_starts(3, cnt);
      oe_n_i = 1'b1;
      count_starts(10, cnt);
      check(cnt == 1, "R10 oe toggle no refire", cnt, 1);

      // R10: write enable bounces while chip enable stays low
      cnt = 0;
      we_n_i = 1'b1;
      count_starts(4, cnt);
      we_n_i = 1'b0;
      count_starts(10, cnt);
      check(cnt == 0, "R10 we bounce no refire", cnt, 0);
      idle_pins(5);

      // R10: re-armed after both high
      run_pulse(5, 1'b1, 1'b1, 1'b1, cnt, first);
      check(cnt == 1, "R10 rearm after release", cnt, 1);

      // R4: supply low raises lockout, full delay after it clears
      supply_low_i = 1'b1;
      repeat (3) @(negedge clk);
      check(lockout_o == 1'b1, "R4 lockout on supply low", lockout_o, 1);
      run_pulse(6, 1'b1, 1'b1, 1'b1, cnt, first);
      check(cnt == 0, "R4 no start while supply low", cnt, 0);
      supply_low_i = 1'b0;
      measure_unlock(n);
      check(n == P + 2, "R4 delay after supply low", n, P + 2);

      // R4: glitch mid-count restarts from zero
      supply_low_i = 1'b1;
      @(negedge clk);
      supply_low_i = 1'b0;
      repeat (P / 2 + 2) @(negedge clk);
      supply_low_i = 1'b1;
      @(negedge clk);
      supply_low_i = 1'b0;
      measure_unlock(n);
      check(n == P + 2, "R4 restart after mid-count glitch", n, P + 2);

      // R5: supply-good drop restarts count
      supply_ok_i = 1'b0;
      repeat (3) @(negedge clk);
      check(lockout_o == 1'b1, "R5 lockout on supply not good", lockout_o, 1);
      supply_ok_i = 1'b1;
      measure_unlock(n);
      check(n == P + 2, "R5 delay after supply good returns", n, P + 2);

      // R11: pulse during power-up lockout is dropped
      supply_ok_i = 1'b0;
      repeat (2) @(negedge clk);
      supply_ok_i = 1'b1;
      run_pulse(6, 1'b1, 1'b1, 1'b1, cnt, first);
      check(cnt == 0, "R11 no start during lockout", cnt, 0);
      measure_unlock(n);
      run_pulse(6, 1'b1, 1'b1, 1'b1, cnt, first);
      check(cnt == 1, "R11 start once unlocked", cnt, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule